// File: doc/BRIEF.md
# Multi-Mode Bit Clock Recovery Loop

This block rebuilds a receive bit clock from a hard-sliced serial bit stream. It runs on a fast system clock, accepts one sliced bit per sample strobe and advances a phase counter by one step per accepted sample, 128 steps per bit period. A change of level between consecutive samples is a data transition. The phase counter value at that sample is the timing error, since the ideal transition lies on the bit boundary at phase zero. The loop moves the phase by an amount that depends on its current bandwidth mode. It presents the recovered clock and one data bit per bit period, taken at mid-bit.

The bandwidth follows two control inputs. While an acquire request is high, the loop corrects strongly so that it pulls in within a few transitions. When the request drops, it runs for 30 bit periods with a medium correction limit and then settles to a narrow limit. An active-low hold input opens the loop so the clock freewheels through a fade.

The sample input is a plain strobed stream with no ready signal: the block takes every strobe and never applies back-pressure. The recovered-bit output is a one-cycle valid pulse with no ready, because the line sets its rate and a stalled bit could not be stored.

Top module: `bitclk_dpll`

## Requirements
- R1: After reset out_valid and out_data are 0, rec_clk is 1, the phase is 0 and the loop is in narrow mode. The first mid-bit sample therefore falls on the 65th accepted strobe (strobe index 64).
- R2: While acq_req is 1 and hold_n is 1, each transition changes the phase by the signed error shifted right arithmetically by one, with no limit. The error is the phase at the transition sample, read as a two's complement number in -64..63. The next phase is phase + 1 - correction, modulo 128. From an error of magnitude up to 40, the error is at most 1 step after 8 transitions.
- R3: For 30 bit ticks after acq_req falls with hold_n high, each transition correction is clipped to ±4 steps, so that two transitions move the phase by at most ±8 steps (1/16 bit).
- R4: Once the medium count is used up, with acq_req low and hold_n high, each transition correction is clipped to ±1 step, at most ±2 steps (1/64 bit) per two transitions.
- R5: While hold_n is 0 the phase advances by exactly one step per strobe, regardless of transitions or acq_req. The medium-mode bit count keeps its value.
- R6: Samples without a level change make no correction, so that bit ticks then come exactly 128 strobes apart.
- R7: Cycles with in_valid low neither advance the phase nor register in_bit.
- R8: A strobe taken at phase 64 produces a one-cycle out_valid pulse on the next cycle, with out_data equal to that strobe's in_bit.
- R9: rec_clk is registered. It is high for phases 96..127 and 0..31 and low otherwise, so that out_data changes only while rec_clk is low and is stable at every rising edge of rec_clk.
- R10: acq_req high with hold_n high clears the medium-mode bit count at any time, so that every fall of acq_req starts a full 30-bit medium interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; one phase step per strobe |
| in_bit | input | 1 | Hard-sliced received level |
| acq_req | input | 1 | High requests fast acquisition |
| hold_n | input | 1 | Low opens the loop (freewheel) |
| out_valid | output | 1 | One-cycle pulse per recovered bit |
| out_data | output | 1 | Recovered bit, held until the next pulse |
| rec_clk | output | 1 | Recovered bit clock |

## Verification
The hardest case to reach from the ports is the exact hand-over from medium to narrow after a hold has frozen the medium bit count part-way through. The count cannot be seen, so the only evidence is the size of one correction on one particular transition. The stimulus releases acquire, inserts a five-bit hold in the middle of the medium interval, and then steps the transmitted phase by 16 steps just before the 30th medium tick. The last medium transition must then move the phase by 4 and the next one by 1, and the strobe index of every mid-bit tick shows which of these happened.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [1:0] {
    LM_ACQ  = 2'd0,
    LM_MED  = 2'd1,
    LM_NAR  = 2'd2,
    LM_HOLD = 2'd3
  } loop_mode_e;

endpackage

// File: rtl/dpll_xing_det.sv
module dpll_xing_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic din,
  output logic xing
);
  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (stb) begin
      prev_q   <= din;
      primed_q <= 1'b1;
    end
  end

  // a level change between two accepted samples
  assign xing = stb & primed_q & (din ^ prev_q);

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_pkg::*;
#(
  parameter int MED_BITS = 30,
  parameter int CNT_W    = $clog2(MED_BITS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_req,
  input  logic       hold_n,
  input  logic       bit_tick,
  output loop_mode_e mode
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MED_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic             med_left;

  assign med_left = (cnt_q < CNT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_END;
    end else if (hold_n && acq_req) begin
      cnt_q <= '0;
    end else if (hold_n && bit_tick && med_left) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // hold outranks acquire; medium runs until the bit count is spent
  always_comb begin
    if (!hold_n)        mode = LM_HOLD;
    else if (acq_req)   mode = LM_ACQ;
    else if (med_left)  mode = LM_MED;
    else                mode = LM_NAR;
  end

endmodule

// File: rtl/dpll_corr_limit.sv
module dpll_corr_limit
  import dpll_pkg::*;
#(
  parameter int PH_BITS   = 7,
  parameter int MED_LIM   = 4,
  parameter int NAR_LIM   = 1,
  parameter int ACQ_SHIFT = 1
) (
  input  loop_mode_e                  mode,
  input  logic                        xing,
  input  logic [PH_BITS-1:0]          phase,
  output logic signed [PH_BITS-1:0]   corr
);
  typedef logic signed [PH_BITS-1:0] serr_t;

  localparam serr_t MED_HI = serr_t'(MED_LIM);
  localparam serr_t MED_LO = serr_t'(-MED_LIM);
  localparam serr_t NAR_HI = serr_t'(NAR_LIM);
  localparam serr_t NAR_LO = serr_t'(-NAR_LIM);

  function automatic serr_t clip(serr_t v, serr_t hi, serr_t lo);
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

  serr_t err;
  assign err = $signed(phase);

  always_comb begin
    corr = '0;
    if (xing) begin
      unique case (mode)
        LM_ACQ:  corr = err >>> ACQ_SHIFT;
        LM_MED:  corr = clip(err, MED_HI, MED_LO);
        LM_NAR:  corr = clip(err, NAR_HI, NAR_LO);
        default: corr = '0;
      endcase
    end
  end

endmodule

// File: rtl/dpll_phase_nco.sv
module dpll_phase_nco #(
  parameter int PH_BITS = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stb,
  input  logic signed [PH_BITS-1:0] corr,
  output logic [PH_BITS-1:0]        phase,
  output logic                      bit_tick,
  output logic                      rclk
);
  localparam logic [PH_BITS-1:0] MID = {1'b1, {(PH_BITS-1){1'b0}}};

  logic [PH_BITS-1:0] ph_next;

  function automatic logic clk_window(logic [PH_BITS-1:0] p);
    // high over the last and first quarter of the bit
    return ~(p[PH_BITS-1] ^ p[PH_BITS-2]);
  endfunction

  assign ph_next  = phase + PH_BITS'(1) - $unsigned(corr);
  assign bit_tick = stb & (phase == MID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      rclk  <= 1'b1;
    end else if (stb) begin
      phase <= ph_next;
      rclk  <= clk_window(ph_next);
    end
  end

endmodule

// File: rtl/bitclk_dpll.sv
module bitclk_dpll
  import dpll_pkg::*;
#(
  parameter int PH_BITS  = 7,
  parameter int MED_BITS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic acq_req,
  input  logic hold_n,
  output logic out_valid,
  output logic out_data,
  output logic rec_clk
);
  localparam int STEPS   = 2 ** PH_BITS;
  localparam int MED_LIM = STEPS / 32;   // per transition, 1/16 per pair
  localparam int NAR_LIM = STEPS / 128;  // per transition, 1/64 per pair
  localparam int CNT_W   = $clog2(MED_BITS + 1);

  logic                      xing;
  logic                      bit_tick;
  logic [PH_BITS-1:0]        phase;
  logic signed [PH_BITS-1:0] corr;
  loop_mode_e                mode;

  dpll_xing_det u_xing (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (in_valid),
    .din  (in_bit),
    .xing (xing)
  );

  dpll_mode_ctrl #(
    .MED_BITS(MED_BITS),
    .CNT_W   (CNT_W)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .acq_req (acq_req),
    .hold_n  (hold_n),
    .bit_tick(bit_tick),
    .mode    (mode)
  );

  dpll_corr_limit #(
    .PH_BITS  (PH_BITS),
    .MED_LIM  (MED_LIM),
    .NAR_LIM  (NAR_LIM),
    .ACQ_SHIFT(1)
  ) u_lim (
    .mode (mode),
    .xing (xing),
    .phase(phase),
    .corr (corr)
  );

  dpll_phase_nco #(
    .PH_BITS(PH_BITS)
  ) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (in_valid),
    .corr    (corr),
    .phase   (phase),
    .bit_tick(bit_tick),
    .rclk    (rec_clk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
    end else begin
      out_valid <= bit_tick;
      if (bit_tick) out_data <= in_bit;
    end
  end

endmodule

// File: rtl/dpll_checker.sv
module dpll_checker
  import dpll_pkg::*;
#(
  parameter int PH_BITS = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               hold_n,
  input logic [PH_BITS-1:0] phase,
  input loop_mode_e         mode,
  input logic               rec_clk,
  input logic               out_valid,
  input logic               out_data
);
  localparam int STEPS   = 2 ** PH_BITS;
  localparam int MED_LIM = STEPS / 32;
  localparam int NAR_LIM = STEPS / 128;

  AST_HOLD_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hold_n) |=> (phase == PH_BITS'($past(phase) + PH_BITS'(1)))); // R5

  AST_MED_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hold_n && mode == LM_MED) |=>
      (PH_BITS'(phase - $past(phase) + PH_BITS'(MED_LIM - 1)) <= PH_BITS'(2 * MED_LIM))); // R3

  AST_NAR_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hold_n && mode == LM_NAR) |=>
      (PH_BITS'(phase - $past(phase) + PH_BITS'(NAR_LIM - 1)) <= PH_BITS'(2 * NAR_LIM))); // R4

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase)); // R7

  AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_clk) |-> $stable(out_data)); // R9

  AST_VALID_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rec_clk); // R9

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8

endmodule

bind bitclk_dpll dpll_checker #(.PH_BITS(PH_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .hold_n   (hold_n),
  .phase    (phase),
  .mode     (mode),
  .rec_clk  (rec_clk),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/sim_bitclk_dpll.sv
module sim_bitclk_dpll;

  localparam int STEPS    = 128;
  localparam int MIDPT    = 64;
  localparam int MED_BITS = 30;
  localparam int NBITS    = 82;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_bit, acq_req, hold_n;
  logic out_valid, out_data, rec_clk;

  bitclk_dpll u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .acq_req  (acq_req),
    .hold_n   (hold_n),
    .out_valid(out_valid),
    .out_data (out_data),
    .rec_clk  (rec_clk)
  );

  typedef struct {
    int    idx;
    bit    d;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails  = 0;
  int   scnt   = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // stimulus plan, one entry per transmitted bit
  function automatic int shift_of(int k);
    case (k)
      0:       return 40;
      11:      return 28;
      21:      return 20;
      45:      return 16;
      71:      return -30;
      75:      return 10;
      default: return 0;
    endcase
  endfunction

  function automatic bit acq_of(int k);
    return (k <= 11) || (k >= 72);
  endfunction

  function automatic bit hold_n_of(int k);
    return !((k >= 20 && k <= 24) || (k >= 76 && k <= 77));
  endfunction

  function automatic bit d_of(int k);
    if (k >= 60 && k <= 63) return 1'b1;
    return k[0];
  endfunction

  // 0 acquire, 1 medium, 2 narrow, 3 hold
  function automatic int mode_of(bit acq, bit hn, int cnt);
    if (!hn)             return 3;
    if (acq)             return 0;
    if (cnt < MED_BITS)  return 1;
    return 2;
  endfunction

  function automatic int clip(int v, int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int corr_of(int md, int e);
    case (md)
      0:       return e >>> 1;
      1:       return clip(e, 4);
      2:       return clip(e, 1);
      default: return 0;
    endcase
  endfunction

  // accepted-strobe counter, independent of the design
  always @(posedge clk) if (rst_n && in_valid) scnt <= scnt + 1;

  // monitor: pops one expected tick per out_valid pulse
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8", "unexpected out_valid at strobe", scnt - 1, -1);
      end else begin
        x = sbq.pop_front();
        check((scnt - 1) == x.idx, x.req, "tick strobe index", scnt - 1, x.idx);
        check(out_data == x.d, "R8", "sampled bit", int'(out_data), int'(x.d));
        check(rec_clk == 1'b0, "R9", "rec_clk at data update", int'(rec_clk), 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // driver
  initial begin
    int    e;
    int    cnt;
    int    t0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_bit   = 1'b0;
    acq_req  = acq_of(0);
    hold_n   = hold_n_of(0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_data == 1'b0, "R1", "out_data in reset", int'(out_data), 0);
    check(rec_clk == 1'b1, "R1", "rec_clk in reset", int'(rec_clk), 1);
    rst_n = 1'b1;

    e   = 0;
    cnt = MED_BITS;
    t0  = 0;
    for (int k = 0; k < NBITS; k++) begin
      int    len;
      bit    xg;
      int    md;
      int    c;
      string lbl;
      exp_t  item;
      len = STEPS + shift_of(k);
      xg  = (k > 0) && (d_of(k) != d_of(k - 1));
      if (acq_of(k) && hold_n_of(k)) cnt = 0;             // R10
      md  = mode_of(acq_of(k), hold_n_of(k), cnt);
      c   = xg ? corr_of(md, e) : 0;
      if (k == 0)        lbl = "R1";
      else if (k == 65)  lbl = "R7";
      else if (!xg)      lbl = "R6";
      else if (md == 0)  lbl = "R2";
      else if (md == 1)  lbl = "R3";
      else if (md == 2)  lbl = "R4";
      else               lbl = "R5";
      item.idx = t0 + MIDPT - e + c;
      item.d   = d_of(k);
      item.req = lbl;
      sbq.push_back(item);
      if (hold_n_of(k) && !acq_of(k) && cnt < MED_BITS) cnt++;

      for (int j = 0; j < len; j++) begin
        @(negedge clk);
        if (k == 65 && j == 10) begin
          for (int g = 0; g < 5; g++) begin
            in_valid = 1'b0;
            in_bit   = !d_of(k);
            @(negedge clk);
          end
        end
        in_valid = 1'b1;
        in_bit   = d_of(k);
        if (j == len - 32 && k + 1 < NBITS) begin
          acq_req = acq_of(k + 1);
          hold_n  = hold_n_of(k + 1);
        end
      end
      e  = e - c + shift_of(k);
      t0 = t0 + len;
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (300) @(negedge clk);
    check(sbq.size() == 0, "R8", "ticks still pending", sbq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule